// File: doc/BRIEF.md
# Power Monitor Serial Command and Readback Target

This block is the two-wire serial target of a supply monitor. A bus master writes a command byte that selects which channel (supply voltage, load current or both) is converted, whether conversions run continuously or once, and whether a read returns measurement codes or a status byte. A written first byte with its top bit set is taken as a pointer to one of three extended configuration registers instead, and the byte that follows is written there. The converter itself lives outside this block. The block raises one conversion-request level per channel and receives a result-valid pulse with a 12-bit code for each.

SCL and SDA are sampled with the system clock through synchronizers. START, STOP, address match, direction and acknowledge are all recovered from the sampled lines. SDA is driven as an open-drain output enable. Reads pack the two 12-bit codes into as few bytes as possible. The packed data is snapshotted when the read address is acknowledged, so a result that arrives during a read cannot tear the frame. While a one-shot conversion is still outstanding, the target refuses its read address, so the master can poll for completion.

Top module: `mon_i2c_target`

## Requirements
- R1: The target acknowledges only the 7-bit address formed by binary 11010 followed by `strap_i[1]`, `strap_i[0]`; any other address is not acknowledged and SDA stays released.
- R2: An address-only write (START, own address with write bit 0, STOP) is acknowledged and changes no register, output or request.
- R3: A first data byte with bit 7 clear is a command: bit 0 voltage continuous, bit 1 voltage once, bit 2 current continuous, bit 3 current once, bit 4 voltage range, bit 6 status read, bit 5 ignored. `conv_v_o` is high while bit 0 or a pending bit 1 is set, and `conv_c_o` likewise for bits 2 and 3.
- R4: A first data byte with bit 7 set selects an extended register by bits 1:0 (0, 1 or 2 map to `ext_cfg_o` bits 7:0, 15:8, 23:16); the next byte is written there, later bytes are ignored, and selector 3 writes nothing. After reset the registers hold `XREG_RST`.
- R5: A once bit clears when that channel's result-valid pulse arrives; while any once bit is pending, a read address is not acknowledged.
- R6: In continuous mode a read before the first result is acknowledged and returns all-zero bytes.
- R7: With both channels selected, a read returns three bytes: voltage 11:4, current 11:4, then voltage 3:0 in the high nibble and current 3:0 in the low nibble.
- R8: With one channel selected, a read returns code bits 11:4, then bits 3:0 in the high nibble with a zero low nibble.
- R9: With status read set, the first read byte is the status: bit 7 voltage result held, bit 5 current result held, bit 4 range, bits 3..0 the current-once, current-continuous, voltage-once and voltage-continuous states, bit 6 zero.
- R10: A master NACK ends the read and SDA stays released until the next START; every START resets the read byte position to the first byte.
- R11: A STOP in the middle of a byte abandons it and no register changes.
- R12: `vrange_o` follows command bit 4 of the last command written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_i | input | 2 | Address strap, low two address bits |
| conv_v_o | output | 1 | Voltage conversion request |
| conv_c_o | output | 1 | Current conversion request |
| volt_done_i | input | 1 | Voltage result valid pulse |
| volt_code_i | input | 12 | Voltage result code |
| curr_done_i | input | 1 | Current result valid pulse |
| curr_code_i | input | 12 | Current result code |
| vrange_o | output | 1 | Voltage range select |
| ext_cfg_o | output | 24 | Three extended registers, register n at bits 8n+7:8n |

## Verification
A wrong bit counter or state in the link engine shows within one byte time as an acknowledge bit in the wrong slot, so the master reads a shifted byte or sees its address refused. A stuck once bit shows within a few clocks of the result pulse as `conv_v_o` or `conv_c_o` staying high, and as a refused read address at the next poll. A wrong snapshot or byte position shows on the first byte of the next read, and a lost byte-position reset shows on the first byte after a repeated START.

// File: rtl/mon_i2c_pkg.sv
`timescale 1ns/1ps
package mon_i2c_pkg;
    localparam int CODE_W      = 12;
    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 3;
    localparam int FRAME_W     = FRAME_BYTES * BYTE_W;
    localparam int IDX_W       = 2;
    localparam int XREG_N      = 3;
    localparam int XREG_W      = XREG_N * BYTE_W;
    localparam logic [4:0] ADDR_HI = 5'b11010;

    localparam int CMD_V_CONT = 0;
    localparam int CMD_V_ONCE = 1;
    localparam int CMD_C_CONT = 2;
    localparam int CMD_C_ONCE = 3;
    localparam int CMD_RANGE  = 4;
    localparam int CMD_SPARE  = 5;
    localparam int CMD_STAT   = 6;
    localparam int CMD_EXT    = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_state_e;
endpackage

// File: rtl/mon_i2c_cond.sv
`timescale 1ns/1ps
module mon_i2c_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_p;
        logic                   sda_p;
    } cond_t;

    cond_t q, n;
    logic scl_s, sda_s;

    assign scl_s = q.scl_sh[SYNC_STAGES-1];
    assign sda_s = q.sda_sh[SYNC_STAGES-1];

    always_comb begin
        n        = q;
        n.scl_sh = {q.scl_sh[SYNC_STAGES-2:0], scl_i};
        n.sda_sh = {q.sda_sh[SYNC_STAGES-2:0], sda_i};
        n.scl_p  = scl_s;
        n.sda_p  = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= n;
    end

    assign scl_lvl_o  = scl_s;
    assign sda_lvl_o  = sda_s;
    assign scl_rise_o = scl_s & ~q.scl_p;
    assign scl_fall_o = ~scl_s & q.scl_p;
    assign start_o    = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_o     = scl_s & q.scl_p & ~q.sda_p & sda_s;
endmodule

// File: rtl/mon_i2c_link.sv
`timescale 1ns/1ps
module mon_i2c_link
    import mon_i2c_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_lvl_i,
    input  logic                sda_lvl_i,
    input  logic                scl_rise_i,
    input  logic                scl_fall_i,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic [1:0]          strap_i,
    input  logic                rd_block_i,
    input  logic [BYTE_W-1:0]   tx_byte_i,
    output logic                sda_oe_o,
    output logic                wr_stb_o,
    output logic                wr_first_o,
    output logic [BYTE_W-1:0]   wr_data_o,
    output logic                rd_open_o,
    output logic [IDX_W-1:0]    byte_idx_o
);
    typedef struct packed {
        bus_state_e         state;
        logic [3:0]         bitcnt;
        logic [BYTE_W-1:0]  shreg;
        logic               is_addr;
        logic               rd;
        logic               first;
        logic               sda_oe;
        logic [IDX_W-1:0]   idx;
        logic               wr_stb;
        logic               wr_first;
        logic               rd_open;
    } link_t;

    localparam logic [3:0] FULL = 4'(BYTE_W);

    link_t q, n;
    logic  addr_hit;

    assign addr_hit = (q.shreg[7:1] == {ADDR_HI, strap_i});

    always_comb begin
        n         = q;
        n.wr_stb  = 1'b0;
        n.rd_open = 1'b0;
        if (stop_i) begin
            n.state  = ST_IDLE;
            n.sda_oe = 1'b0;
        end else if (start_i) begin
            n.state   = ST_RX;
            n.is_addr = 1'b1;
            n.bitcnt  = '0;
            n.sda_oe  = 1'b0;
            n.idx     = '0;
        end else begin
            case (q.state)
                ST_RX: begin
                    if (scl_rise_i && q.bitcnt < FULL) begin
                        n.shreg  = {q.shreg[BYTE_W-2:0], sda_lvl_i};
                        n.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall_i && q.bitcnt == FULL) begin
                        if (q.is_addr) begin
                            if (addr_hit && (!q.shreg[0] || !rd_block_i)) begin
                                n.state   = ST_ACK;
                                n.sda_oe  = 1'b1;
                                n.rd      = q.shreg[0];
                                n.first   = 1'b1;
                                n.rd_open = q.shreg[0];
                            end else begin
                                n.state = ST_IDLE;
                            end
                        end else begin
                            n.state    = ST_ACK;
                            n.sda_oe   = 1'b1;
                            n.wr_stb   = 1'b1;
                            n.wr_first = q.first;
                            n.first    = 1'b0;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        n.is_addr = 1'b0;
                        n.bitcnt  = '0;
                        if (q.rd) begin
                            n.state  = ST_TX;
                            n.shreg  = tx_byte_i;
                            n.sda_oe = ~tx_byte_i[BYTE_W-1];
                        end else begin
                            n.state  = ST_RX;
                            n.sda_oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise_i && q.bitcnt < FULL) begin
                        n.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall_i && q.bitcnt == FULL) begin
                        n.state  = ST_MACK;
                        n.sda_oe = 1'b0;
                    end else if (scl_fall_i && q.bitcnt != 4'd0) begin
                        n.shreg  = {q.shreg[BYTE_W-2:0], 1'b0};
                        n.sda_oe = ~q.shreg[BYTE_W-2];
                    end
                end
                ST_MACK: begin
                    if (scl_rise_i) begin
                        if (sda_lvl_i) begin
                            n.state = ST_IDLE;
                        end else if (q.idx != '1) begin
                            n.idx = q.idx + 1'b1;
                        end
                    end else if (scl_fall_i) begin
                        n.state  = ST_TX;
                        n.bitcnt = '0;
                        n.shreg  = tx_byte_i;
                        n.sda_oe = ~tx_byte_i[BYTE_W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, default: '0};
        else        q <= n;
    end

    assign sda_oe_o   = q.sda_oe;
    assign wr_stb_o   = q.wr_stb;
    assign wr_first_o = q.wr_first;
    assign wr_data_o  = q.shreg;
    assign rd_open_o  = q.rd_open;
    assign byte_idx_o = q.idx;

    // R11: a STOP always returns the engine to idle with SDA released
    a_r11_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (q.state == ST_IDLE) && !q.sda_oe);

    // R10: the target only starts pulling SDA while SCL is low
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sda_oe) |-> !scl_lvl_i);

    // R1: an address acknowledge only follows our own address
    a_r1_ack_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.sda_oe) && q.is_addr) |-> (q.shreg[7:1] == {ADDR_HI, strap_i}));

    // R5: a read address is refused while a one-shot conversion is pending
    a_r5_pending_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RX && q.is_addr && scl_fall_i && q.bitcnt == FULL
         && q.shreg[0] && rd_block_i) |=> !q.sda_oe);
endmodule

// File: rtl/mon_i2c_regs.sv
`timescale 1ns/1ps
module mon_i2c_regs
    import mon_i2c_pkg::*;
#(
    parameter logic [XREG_W-1:0] XREG_RST = 24'h5AA53C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb_i,
    input  logic                wr_first_i,
    input  logic [BYTE_W-1:0]   wr_data_i,
    input  logic                rd_open_i,
    input  logic [IDX_W-1:0]    byte_idx_i,
    input  logic                volt_done_i,
    input  logic [CODE_W-1:0]   volt_code_i,
    input  logic                curr_done_i,
    input  logic [CODE_W-1:0]   curr_code_i,
    output logic                rd_block_o,
    output logic [BYTE_W-1:0]   tx_byte_o,
    output logic                conv_v_o,
    output logic                conv_c_o,
    output logic                vrange_o,
    output logic [XREG_W-1:0]   ext_cfg_o
);
    typedef struct packed {
        logic               cont_v;
        logic               once_v;
        logic               cont_c;
        logic               once_c;
        logic               vrange;
        logic               stat;
        logic               sel_v;
        logic               sel_c;
        logic [1:0]         xptr;
        logic               xarm;
        logic [XREG_W-1:0]  xreg;
        logic [CODE_W-1:0]  vres;
        logic [CODE_W-1:0]  cres;
        logic               vval;
        logic               cval;
        logic [FRAME_W-1:0] snap;
    } regs_t;

    regs_t               q, n;
    logic [FRAME_W-1:0]  frame;
    logic [BYTE_W-1:0]   status;
    logic                wr_cmd;
    logic                spare_unused;

    assign spare_unused = wr_data_i[CMD_SPARE];
    assign wr_cmd = wr_stb_i && wr_first_i && !wr_data_i[CMD_EXT];

    assign status = {q.vval, 1'b0, q.cval, q.vrange,
                     q.once_c, q.cont_c, q.once_v, q.cont_v};

    always_comb begin
        if (q.stat)
            frame = {status, {(FRAME_W-BYTE_W){1'b0}}};
        else if (q.sel_v && q.sel_c)
            frame = {q.vres[11:4], q.cres[11:4], q.vres[3:0], q.cres[3:0]};
        else if (q.sel_v)
            frame = {q.vres[11:4], q.vres[3:0], 4'h0, 8'h00};
        else if (q.sel_c)
            frame = {q.cres[11:4], q.cres[3:0], 4'h0, 8'h00};
        else
            frame = '0;
    end

    always_comb begin
        n = q;
        if (volt_done_i) begin
            n.vres   = volt_code_i;
            n.vval   = 1'b1;
            n.once_v = 1'b0;
        end
        if (curr_done_i) begin
            n.cres   = curr_code_i;
            n.cval   = 1'b1;
            n.once_c = 1'b0;
        end
        if (wr_stb_i) begin
            if (wr_first_i) begin
                if (wr_data_i[CMD_EXT]) begin
                    n.xptr = wr_data_i[1:0];
                    n.xarm = 1'b1;
                end else begin
                    n.cont_v = wr_data_i[CMD_V_CONT];
                    n.once_v = wr_data_i[CMD_V_ONCE];
                    n.cont_c = wr_data_i[CMD_C_CONT];
                    n.once_c = wr_data_i[CMD_C_ONCE];
                    n.vrange = wr_data_i[CMD_RANGE];
                    n.stat   = wr_data_i[CMD_STAT];
                    n.sel_v  = wr_data_i[CMD_V_CONT] | wr_data_i[CMD_V_ONCE];
                    n.sel_c  = wr_data_i[CMD_C_CONT] | wr_data_i[CMD_C_ONCE];
                    n.xarm   = 1'b0;
                end
            end else if (q.xarm) begin
                for (int i = 0; i < XREG_N; i++) begin
                    if (q.xptr == 2'(i)) n.xreg[i*BYTE_W +: BYTE_W] = wr_data_i;
                end
                n.xarm = 1'b0;
            end
        end
        if (rd_open_i) n.snap = frame;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{xreg: XREG_RST, default: '0};
        else        q <= n;
    end

    always_comb begin
        case (byte_idx_i)
            2'd0:    tx_byte_o = q.snap[FRAME_W-1 -: BYTE_W];
            2'd1:    tx_byte_o = q.snap[FRAME_W-BYTE_W-1 -: BYTE_W];
            2'd2:    tx_byte_o = q.snap[BYTE_W-1:0];
            default: tx_byte_o = '0;
        endcase
    end

    assign rd_block_o = q.once_v | q.once_c;
    assign conv_v_o   = q.cont_v | q.once_v;
    assign conv_c_o   = q.cont_c | q.once_c;
    assign vrange_o   = q.vrange;
    assign ext_cfg_o  = q.xreg;

    // R5: a pending once bit is cleared by its result pulse
    a_r5_once_v_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (q.once_v && volt_done_i && !wr_cmd) |=> !q.once_v);
    a_r5_once_c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (q.once_c && curr_done_i && !wr_cmd) |=> !q.once_c);

    // R4: without a write strobe the extended registers hold
    a_r4_xreg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_i |=> $stable(q.xreg));
endmodule

// File: rtl/mon_i2c_target.sv
`timescale 1ns/1ps
module mon_i2c_target
    import mon_i2c_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [XREG_W-1:0] XREG_RST    = 24'h5AA53C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    input  logic [1:0]          strap_i,
    output logic                conv_v_o,
    output logic                conv_c_o,
    input  logic                volt_done_i,
    input  logic [CODE_W-1:0]   volt_code_i,
    input  logic                curr_done_i,
    input  logic [CODE_W-1:0]   curr_code_i,
    output logic                vrange_o,
    output logic [XREG_W-1:0]   ext_cfg_o
);
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              rd_block, wr_stb, wr_first, rd_open;
    logic [BYTE_W-1:0] tx_byte, wr_data;
    logic [IDX_W-1:0]  byte_idx;

    mon_i2c_cond #(.SYNC_STAGES(SYNC_STAGES)) i_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_det), .stop_o(stop_det)
    );

    mon_i2c_link i_link (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl_i(scl_lvl), .sda_lvl_i(sda_lvl),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_det), .stop_i(stop_det),
        .strap_i(strap_i), .rd_block_i(rd_block), .tx_byte_i(tx_byte),
        .sda_oe_o(sda_oe_o), .wr_stb_o(wr_stb), .wr_first_o(wr_first),
        .wr_data_o(wr_data), .rd_open_o(rd_open), .byte_idx_o(byte_idx)
    );

    mon_i2c_regs #(.XREG_RST(XREG_RST)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_stb_i(wr_stb), .wr_first_i(wr_first), .wr_data_i(wr_data),
        .rd_open_i(rd_open), .byte_idx_i(byte_idx),
        .volt_done_i(volt_done_i), .volt_code_i(volt_code_i),
        .curr_done_i(curr_done_i), .curr_code_i(curr_code_i),
        .rd_block_o(rd_block), .tx_byte_o(tx_byte),
        .conv_v_o(conv_v_o), .conv_c_o(conv_c_o),
        .vrange_o(vrange_o), .ext_cfg_o(ext_cfg_o)
    );
endmodule

// File: tb/test_mon_i2c_target.sv
`timescale 1ns/1ps
module test_mon_i2c_target;
    localparam int H = 10;
    localparam logic [23:0] XDEF = 24'h5AA53C;
    localparam logic [7:0] WR_A = 8'hD4;   // 11010 + strap 10 + write
    localparam logic [7:0] RD_A = 8'hD5;
    // vectors: cmd[31:24], voltage code[23:12], current code[11:0]
    localparam logic [31:0] VEC [6] = '{
        {8'h0A, 12'hABC, 12'h123},
        {8'h02, 12'h5F1, 12'h777},
        {8'h08, 12'h444, 12'h9E7},
        {8'h05, 12'hFFF, 12'h001},
        {8'h01, 12'h800, 12'h0F0},
        {8'h0B, 12'h321, 12'hFED}
    };

    logic clk = 0, rst_n = 0;
    logic scl_m = 1, sda_m = 1;
    logic sda_oe, conv_v, conv_c, vrange;
    logic volt_done = 0, curr_done = 0;
    logic [11:0] vcode = 0, ccode = 0;
    logic [23:0] ext_cfg;
    logic adc_en = 0;
    wire  sda_line = sda_m & ~sda_oe;
    int   n_run = 0, n_fail = 0;
    bit   finished = 0;

    always #2 clk = ~clk;

    mon_i2c_target i_mon_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_i(2'b10),
        .conv_v_o(conv_v), .conv_c_o(conv_c),
        .volt_done_i(volt_done), .volt_code_i(vcode),
        .curr_done_i(curr_done), .curr_code_i(ccode),
        .vrange_o(vrange), .ext_cfg_o(ext_cfg)
    );

    // converter model: a result 16 clocks into each request
    initial begin
        int vc = 0, cc = 0;
        forever begin
            @(negedge clk);
            volt_done = 0; curr_done = 0;
            if (adc_en && conv_v) begin vc++; if (vc == 16) begin volt_done = 1; vc = 0; end end
            else vc = 0;
            if (adc_en && conv_c) begin cc++; if (cc == 16) begin curr_done = 1; cc = 0; end end
            else cc = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n); repeat (n) @(negedge clk); endtask

    task automatic b_start; sda_m = 1; wt(2); scl_m = 1; wt(H); sda_m = 0; wt(H); scl_m = 0; wt(2); endtask
    task automatic b_stop;  sda_m = 0; wt(H); scl_m = 1; wt(H); sda_m = 1; wt(H); endtask
    task automatic send_bit(input bit b); sda_m = b; wt(H); scl_m = 1; wt(H); scl_m = 0; wt(2); endtask
    task automatic recv_bit(output bit b);
        sda_m = 1; wt(H); scl_m = 1; wt(H/2); b = sda_line; wt(H/2); scl_m = 0; wt(2);
    endtask
    task automatic wr_byte(input logic [7:0] d, output bit ack);
        bit v;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(v); ack = !v;
    endtask
    task automatic rd_byte(input bit last, output logic [7:0] d);
        bit v;
        for (int i = 7; i >= 0; i--) begin recv_bit(v); d[i] = v; end
        send_bit(last);
    endtask
    task automatic xfer_wr(input int n, input logic [7:0] d0, input logic [7:0] d1, output bit aack);
        bit a;
        b_start; wr_byte(WR_A, aack);
        if (aack && n > 0) wr_byte(d0, a);
        if (aack && n > 1) wr_byte(d1, a);
        b_stop;
    endtask
    task automatic xfer_rd(input int n, output bit aack, output logic [23:0] data);
        logic [7:0] b;
        data = '0;
        b_start; wr_byte(RD_A, aack);
        if (aack) for (int i = 0; i < n; i++) begin
            rd_byte(i == n-1, b); data[23-8*i -: 8] = b;
        end
        b_stop;
    endtask

    function automatic logic [23:0] exp_frame(input logic [7:0] c, input logic [11:0] v, input logic [11:0] i);
        bit sv = c[0] | c[1], sc = c[2] | c[3];
        if (sv && sc) return {v[11:4], i[11:4], v[3:0], i[3:0]};
        if (sv)       return {v[11:4], v[3:0], 4'h0, 8'h00};
        if (sc)       return {i[11:4], i[3:0], 4'h0, 8'h00};
        return 24'h0;
    endfunction
    function automatic int exp_len(input logic [7:0] c);
        bit sv = c[0] | c[1], sc = c[2] | c[3];
        return (sv && sc) ? 3 : ((sv || sc) ? 2 : 1);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [23:0] d;
        logic [7:0] b;
        wt(5); rst_n = 1; wt(5);

        // reset state (R3, R4, R12)
        chk(sda_oe == 0, "R10 reset sda released", sda_oe, 0);
        chk(conv_v == 0 && conv_c == 0, "R3 reset no request", {conv_v, conv_c}, 0);
        chk(ext_cfg == XDEF, "R4 ext defaults", ext_cfg, XDEF);
        chk(vrange == 0, "R12 reset range", vrange, 0);

        // R1: foreign address refused
        b_start; wr_byte(8'hD0, ack); b_stop;
        chk(!ack, "R1 foreign address NACK", ack, 0);
        b_start; wr_byte(8'hD6, ack); b_stop;
        chk(!ack, "R1 other strap NACK", ack, 0);
        // R2: quick command
        xfer_wr(0, 8'h00, 8'h00, ack);
        chk(ack, "R1 R2 own address ACK", ack, 1);
        chk(conv_v == 0 && conv_c == 0 && ext_cfg == XDEF, "R2 quick command no change",
            {conv_v, conv_c, ext_cfg}, {2'b00, XDEF});

        // R6: continuous, no result yet
        xfer_wr(1, 8'h01, 8'h00, ack);
        chk(conv_v == 1 && conv_c == 0, "R3 continuous voltage request", {conv_v, conv_c}, 2'b10);
        xfer_rd(2, ack, d);
        chk(ack, "R6 read ACK before first result", ack, 1);
        chk(d == 24'h0, "R6 zero data", d, 0);

        // R5: one-shot pending
        vcode = 12'h6C5;
        xfer_wr(1, 8'h02, 8'h00, ack);
        xfer_rd(2, ack, d);
        chk(!ack, "R5 read NACK while pending", ack, 0);
        adc_en = 1; wt(100);
        chk(conv_v == 0, "R5 once bit cleared", conv_v, 0);
        xfer_rd(2, ack, d);
        chk(ack && d == 24'h6C5000, "R5 R8 read after completion", d, 24'h6C5000);

        // table of vectors (R7, R8)
        for (int k = 0; k < 6; k++) begin
            logic [7:0] c = VEC[k][31:24];
            logic [23:0] e;
            vcode = VEC[k][23:12]; ccode = VEC[k][11:0];
            xfer_wr(1, c, 8'h00, ack);
            wt(200);
            e = exp_frame(c, vcode, ccode);
            xfer_rd(exp_len(c), ack, d);
            chk(ack && d == e, (exp_len(c) == 3) ? "R7 packed frame" : "R8 single channel frame", d, e);
        end

        // R4: extended registers
        xfer_wr(1, 8'h00, 8'h00, ack);
        xfer_wr(2, 8'h81, 8'h77, ack);
        chk(ext_cfg == 24'h5A773C, "R4 write register 1", ext_cfg, 24'h5A773C);
        xfer_wr(2, 8'h83, 8'h99, ack);
        chk(ext_cfg == 24'h5A773C, "R4 selector 3 ignored", ext_cfg, 24'h5A773C);
        b_start; wr_byte(WR_A, ack); wr_byte(8'h82, ack); wr_byte(8'h11, ack); wr_byte(8'h22, ack); b_stop;
        chk(ext_cfg == 24'h11773C, "R4 one byte per pointer", ext_cfg, 24'h11773C);

        // R11: STOP inside a byte
        b_start; wr_byte(WR_A, ack); wr_byte(8'h80, ack);
        send_bit(1); send_bit(1); send_bit(0); b_stop;
        chk(ext_cfg == 24'h11773C, "R11 partial byte abandoned", ext_cfg, 24'h11773C);
        xfer_wr(2, 8'h80, 8'hC3, ack);
        chk(ext_cfg == 24'h1177C3, "R11 recovery after abandon", ext_cfg, 24'h1177C3);

        // R9, R12: status byte
        xfer_wr(1, 8'h55, 8'h00, ack);
        wt(100);
        chk(vrange == 1, "R12 range set", vrange, 1);
        xfer_rd(1, ack, d);
        chk(ack && d[23:16] == 8'hB5, "R9 status byte", d[23:16], 8'hB5);
        xfer_wr(1, 8'h00, 8'h00, ack);
        chk(vrange == 0, "R12 range cleared", vrange, 0);

        // R10: master NACK, byte position reset on START
        vcode = 12'h4D2; ccode = 12'h0B7;
        xfer_wr(1, 8'h0A, 8'h00, ack);
        wt(200);
        b_start; wr_byte(RD_A, ack); rd_byte(1, b);
        chk(b == 8'h4D, "R10 first byte", b, 8'h4D);
        rd_byte(1, b);
        chk(b == 8'hFF, "R10 released after master NACK", b, 8'hFF);
        b_start; wr_byte(RD_A, ack); rd_byte(0, b);
        chk(ack && b == 8'h4D, "R10 position reset on START", b, 8'h4D);
        rd_byte(1, b); b_stop;
        chk(b == 8'h0B, "R10 second byte follows", b, 8'h0B);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule